// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Core

This block is a free-running up-counter. It advances on a functional clock, either on every cycle or through a power-of-two prescaler. When it rolls past its maximum value it either wraps to zero or restarts from a programmable reload value. While it runs it can flag a compare hit against a programmable match value. It can also latch its current count when a selected edge appears on an external capture pin. Each of these three events sets a sticky status flag. Software clears a flag by writing a one to it.

The status flags pass through two independent enable masks. One mask drives an interrupt line and the other drives a wakeup line. A timer output pin is also produced. It either pulses for one cycle or toggles on every overflow or compare hit, starting from a selectable idle level. A separate output reports whether that pin should be driven. All configuration and data go through one synchronous port: a write strobe, a read strobe, a shared word address, and a read data bus that is registered.

Top module: `tick_timer`

## Requirements
- R1: Control bit 0 (run) makes the counter add one each functional clock while it is set. While run is clear, the count holds its value.
- R2: When the counter increments from the all-ones value, status bit 1 (overflow) sets. The count becomes zero if control bit 1 (auto-reload) is clear, or the reload register value if auto-reload is set.
- R3: With control bit 5 (prescale enable) set, the counter advances once every 2^(N+1) clocks after the start write. N is control bits 4:2. With bit 5 clear, the counter advances every clock and N is ignored.
- R4: A write of any data to the trigger register loads the count from the reload register. A direct write to the count register loads the written data. A host write to either one takes priority over an increment in the same cycle.
- R5: With control bit 6 (compare enable) set, status bit 0 (match) sets when an increment gives the counter a value equal to the match register. With bit 6 clear, no match is flagged.
- R6: Control bits 9:8 select the capture edge on the capture pin: 00 none, 01 rising, 10 falling, 11 both. A selected edge copies the current count into the capture register and sets status bit 2 (capture).
- R7: With control bit 13 (first-capture hold) set, an edge that arrives while status bit 2 is already set raises no new value: the capture register keeps its earlier value. With bit 13 clear, every selected edge overwrites it.
- R8: Writing a one to a status bit clears that bit, and writing zero leaves it unchanged. If an event sets the bit in the same cycle as the clear, the set wins.
- R9: The interrupt output is registered, one cycle after the status. It is high when any status bit is set whose interrupt-enable bit is also set. The wakeup output does the same with its own wakeup-enable mask.
- R10: The timer output rests at control bit 7 (idle level). With control bit 12 clear, each overflow or flagged match inverts the output for exactly one cycle. With bit 12 set, each such event toggles the output. A trigger write returns the output to the idle level.
- R11: The output-enable port is the inverse of control bit 14 (pin as input), registered one cycle after the control register.
- R12: The word addresses are: control 0, count 1, reload 2, trigger 3, match 4, capture 5, status 6, interrupt enable 7, wakeup enable 8. The read data is registered on the read strobe. After reset every register reads zero, interrupt, wakeup and timer output are low, and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address for read and write |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| cap_pin | input | 1 | External capture input |
| tmr_out | output | 1 | Pulse or toggle timer output |
| tmr_out_en | output | 1 | High when the timer pin should be driven |
| irq | output | 1 | Masked status interrupt |
| wake | output | 1 | Masked status wakeup |

## Verification
The collision that matters is a write-one-to-clear of the status register arriving on the same clock edge as a fresh capture event for that same flag. The bench raises the capture pin edge and the status clear write on one falling edge. It then reads status back and expects the capture flag still set; a second, lone clear must then remove it. A second collision is a direct count write landing on a cycle where the running counter would also increment. The bench checks that the written value, plus only the later increments, ends up in the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word addresses
  localparam int A_CTRL   = 0;
  localparam int A_COUNT  = 1;
  localparam int A_RELOAD = 2;
  localparam int A_TRIG   = 3;
  localparam int A_MATCH  = 4;
  localparam int A_CAPT   = 5;
  localparam int A_STAT   = 6;
  localparam int A_IRQEN  = 7;
  localparam int A_WAKEEN = 8;

  // control word bit positions
  localparam int CTRL_W    = 15;
  localparam int PTV_W     = 3;
  localparam int C_RUN     = 0;
  localparam int C_AUTO    = 1;
  localparam int C_PTV_LO  = 2;
  localparam int C_PRE     = 5;
  localparam int C_CMP     = 6;
  localparam int C_IDLE    = 7;
  localparam int C_EDGE_LO = 8;
  localparam int C_TOGGLE  = 12;
  localparam int C_FIRST   = 13;
  localparam int C_PIN_IN  = 14;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 15'h73FF;

  // status flag positions
  localparam int F_MATCH = 0;
  localparam int F_OVF   = 1;
  localparam int F_CAP   = 2;
  localparam int NFLAG   = 3;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_en,
  input  logic             restart,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  // largest division is 2^(2^PTV_W)
  localparam int DIV_W = (1 << PTV_W);
  localparam logic [DIV_W-1:0] ONE_D = 1;
  localparam logic [DIV_W:0]   ONE_W = 1;
  localparam logic [PTV_W:0]   ONE_S = 1;

  logic [DIV_W-1:0] div;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] lim;
  logic             at_lim;

  assign span   = ONE_W << ({1'b0, ptv} + ONE_S);
  assign lim    = span[DIV_W-1:0] - ONE_D;
  assign at_lim = (div == lim);
  assign tick   = run & (~pre_en | at_lim);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      div <= '0;
    end else if (pre_en) begin
      div <= at_lim ? '0 : div + ONE_D;
    end
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  edge_sel_e        esel,
  input  logic             first_only,
  input  logic             held,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             evt
);
  logic pin_q;
  logic rise;
  logic fall;
  logic take;

  assign rise = pin & ~pin_q;
  assign fall = ~pin & pin_q;

  always_comb begin
    case (esel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  assign take = evt & ~(first_only & held);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q   <= 1'b0;
      cap_val <= '0;
    end else begin
      pin_q <= pin;
      if (take) cap_val <= cnt;
    end
  end
endmodule

// File: rtl/tmr_outgen.sv
module tmr_outgen (
  input  logic clk,
  input  logic rst,
  input  logic idle_lvl,
  input  logic toggle_mode,
  input  logic event_in,
  input  logic rearm,
  output logic pin_out
);
  logic phase;
  logic phase_nx;

  always_comb begin
    if (rearm)                        phase_nx = 1'b0;
    else if (toggle_mode && event_in) phase_nx = ~phase;
    else                              phase_nx = phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      phase   <= phase_nx;
      pin_out <= idle_lvl ^ (toggle_mode ? phase_nx : event_in);
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              cap_pin,
  output logic              tmr_out,
  output logic              tmr_out_en,
  output logic              irq,
  output logic              wake
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  match_val;
  logic [CNT_W-1:0]  cap_val;
  logic [NFLAG-1:0]  stat;
  logic [NFLAG-1:0]  irq_en;
  logic [NFLAG-1:0]  wake_en;
  logic [NFLAG-1:0]  flag_set;
  logic [NFLAG-1:0]  flag_clr;

  // write decode
  logic wr_ctrl, wr_count, wr_reload, wr_trig, wr_match, wr_stat, wr_irqen, wr_wakeen;
  assign wr_ctrl   = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_count  = wr_en && (addr == ADDR_W'(A_COUNT));
  assign wr_reload = wr_en && (addr == ADDR_W'(A_RELOAD));
  assign wr_trig   = wr_en && (addr == ADDR_W'(A_TRIG));
  assign wr_match  = wr_en && (addr == ADDR_W'(A_MATCH));
  assign wr_stat   = wr_en && (addr == ADDR_W'(A_STAT));
  assign wr_irqen  = wr_en && (addr == ADDR_W'(A_IRQEN));
  assign wr_wakeen = wr_en && (addr == ADDR_W'(A_WAKEEN));

  // control fields
  logic             run, auto_rl, pre_en, cmp_en, idle_lvl, toggle_mode, first_only, pin_in;
  logic [PTV_W-1:0] ptv;
  edge_sel_e        esel;
  assign run         = ctrl[C_RUN];
  assign auto_rl     = ctrl[C_AUTO];
  assign ptv         = ctrl[C_PTV_LO +: PTV_W];
  assign pre_en      = ctrl[C_PRE];
  assign cmp_en      = ctrl[C_CMP];
  assign idle_lvl    = ctrl[C_IDLE];
  assign esel        = edge_sel_e'(ctrl[C_EDGE_LO +: 2]);
  assign toggle_mode = ctrl[C_TOGGLE];
  assign first_only  = ctrl[C_FIRST];
  assign pin_in      = ctrl[C_PIN_IN];

  // prescaler
  logic tick;
  tmr_prescale #(.PTV_W(PTV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .pre_en  (pre_en),
    .restart (wr_ctrl),
    .ptv     (ptv),
    .tick    (tick)
  );

  // counter
  logic             host_cnt_wr;
  logic             at_max;
  logic [CNT_W-1:0] cnt_inc;
  logic             ovf_evt;
  logic             match_evt;

  assign host_cnt_wr = wr_count | wr_trig;
  assign at_max      = (cnt == CNT_MAX);
  assign cnt_inc     = at_max ? (auto_rl ? reload : '0) : cnt + CNT_ONE;
  assign ovf_evt     = tick & ~host_cnt_wr & at_max;
  assign match_evt   = tick & ~host_cnt_wr & cmp_en & (cnt_inc == match_val);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (wr_count) cnt <= wdata;
    else if (wr_trig)  cnt <= reload;
    else if (tick)     cnt <= cnt_inc;
  end

  // capture
  logic cap_evt;
  tmr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .pin        (cap_pin),
    .esel       (esel),
    .first_only (first_only),
    .held       (stat[F_CAP]),
    .cnt        (cnt),
    .cap_val    (cap_val),
    .evt        (cap_evt)
  );

  // status flags: set has priority over write-one clear
  assign flag_set[F_MATCH] = match_evt;
  assign flag_set[F_OVF]   = ovf_evt;
  assign flag_set[F_CAP]   = cap_evt;
  assign flag_clr          = wr_stat ? wdata[NFLAG-1:0] : '0;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) stat[g] <= 1'b0;
      else     stat[g] <= flag_set[g] | (stat[g] & ~flag_clr[g]);
    end
  end

  // output pin
  tmr_outgen u_out (
    .clk         (clk),
    .rst         (rst),
    .idle_lvl    (idle_lvl),
    .toggle_mode (toggle_mode),
    .event_in    (ovf_evt | match_evt),
    .rearm       (wr_trig),
    .pin_out     (tmr_out)
  );

  // configuration registers and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      reload     <= '0;
      match_val  <= '0;
      irq_en     <= '0;
      wake_en    <= '0;
      irq        <= 1'b0;
      wake       <= 1'b0;
      tmr_out_en <= 1'b1;
    end else begin
      if (wr_ctrl)   ctrl      <= wdata[CTRL_W-1:0] & CTRL_MASK;
      if (wr_reload) reload    <= wdata;
      if (wr_match)  match_val <= wdata;
      if (wr_irqen)  irq_en    <= wdata[NFLAG-1:0];
      if (wr_wakeen) wake_en   <= wdata[NFLAG-1:0];
      irq        <= |(stat & irq_en);
      wake       <= |(stat & wake_en);
      tmr_out_en <= ~pin_in;
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(A_CTRL):   rdata <= CNT_W'(ctrl);
        ADDR_W'(A_COUNT):  rdata <= cnt;
        ADDR_W'(A_RELOAD): rdata <= reload;
        ADDR_W'(A_MATCH):  rdata <= match_val;
        ADDR_W'(A_CAPT):   rdata <= cap_val;
        ADDR_W'(A_STAT):   rdata <= CNT_W'(stat);
        ADDR_W'(A_IRQEN):  rdata <= CNT_W'(irq_en);
        ADDR_W'(A_WAKEEN): rdata <= CNT_W'(wake_en);
        default:           rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32,
  parameter int NF    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             auto_rl,
  input logic             pre_en,
  input logic             wr_ctrl,
  input logic             wr_trig,
  input logic             wr_stat,
  input logic             host_cnt_wr,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic [NF-1:0]    stat,
  input logic [NF-1:0]    flag_set,
  input logic [NF-1:0]    wdata_lo,
  input logic [NF-1:0]    irq_en,
  input logic [NF-1:0]    wake_en,
  input logic             irq,
  input logic             wake,
  input logic             pin_in,
  input logic             tmr_out_en
);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!run && !host_cnt_wr) |=> $stable(cnt));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !host_cnt_wr && !auto_rl && (&cnt)) |=> (cnt == '0));

  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !host_cnt_wr && auto_rl && (&cnt)) |=> (cnt == $past(reload)));

  p_ovf_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !host_cnt_wr && (&cnt)) |=> stat[1]);

  p_spaced_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (run && pre_en && tick && !wr_ctrl) |=> !tick);

  p_trig_load_r4: assert property (@(posedge clk) disable iff (rst)
    wr_trig |=> (cnt == $past(reload)));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata_lo[0] && !flag_set[0]) |=> !stat[0]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    flag_set[2] |=> stat[2]);

  p_irq_on_r9: assert property (@(posedge clk) disable iff (rst)
    (|(stat & irq_en)) |=> irq);

  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & irq_en)) |=> !irq);

  p_wake_on_r9: assert property (@(posedge clk) disable iff (rst)
    (|(stat & wake_en)) |=> wake);

  p_oe_r11: assert property (@(posedge clk) disable iff (rst)
    pin_in |=> !tmr_out_en);
endmodule

bind tick_timer tmr_checker #(.CNT_W(CNT_W), .NF(tmr_pkg::NFLAG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run         (run),
  .auto_rl     (auto_rl),
  .pre_en      (pre_en),
  .wr_ctrl     (wr_ctrl),
  .wr_trig     (wr_trig),
  .wr_stat     (wr_stat),
  .host_cnt_wr (host_cnt_wr),
  .tick        (tick),
  .cnt         (cnt),
  .reload      (reload),
  .stat        (stat),
  .flag_set    (flag_set),
  .wdata_lo    (wdata[tmr_pkg::NFLAG-1:0]),
  .irq_en      (irq_en),
  .wake_en     (wake_en),
  .irq         (irq),
  .wake        (wake),
  .pin_in      (pin_in),
  .tmr_out_en  (tmr_out_en)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  localparam int CW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          cap_pin = 1'b0;
  logic          tmr_out, tmr_out_en, irq, wake;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [CW-1:0] rv;

  tick_timer #(.CNT_W(CW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_pin(cap_pin), .tmr_out(tmr_out),
    .tmr_out_en(tmr_out_en), .irq(irq), .wake(wake)
  );

  always #2.5 clk = ~clk;

  localparam int AC = 0, ACNT = 1, ARL = 2, ATRG = 3, AMT = 4, ACAP = 5, AST = 6, AIE = 7, AWE = 8;

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(posedge clk); #1;
    rd_en = 1'b0;
    rv = rdata;
  endtask

  // start with cv (run bit forced), n counting edges in total, then stop
  task automatic run_for(input logic [CW-1:0] cv, input int n);
    wr(AC, cv | 32'h1);
    repeat (n - 1) @(posedge clk);
    wr(AC, cv & ~32'h1);
  endtask

  task automatic pin_edge(input logic lvl);
    @(negedge clk);
    cap_pin = lvl;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R12 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(a);
      chk($sformatf("R12 reset reg %0d", a), rv, '0);
    end
    chk("R12 reset irq", {31'b0, irq}, 0);
    chk("R12 reset wake", {31'b0, wake}, 0);
    chk("R12 reset out", {31'b0, tmr_out}, 0);
    chk("R12 reset out_en", {31'b0, tmr_out_en}, 1);

    // R1 start / stop
    wr(ACNT, 10);
    run_for(32'h0, 5);
    rd(ACNT); chk("R1 count after 5 edges", rv, 15);
    repeat (10) @(posedge clk);
    rd(ACNT); chk("R1 held while stopped", rv, 15);

    // R3 prescaler sweep over every division setting
    for (int p = 0; p < 8; p++) begin
      int per;
      per = 1 << (p + 1);
      wr(ACNT, 0);
      run_for(32'h20 | (p << 2), 3 * per + per / 2);
      rd(ACNT); chk($sformatf("R3 prescale N=%0d", p), rv, 3);
    end
    wr(ACNT, 0);
    run_for(32'h1C, 6);
    rd(ACNT); chk("R3 N ignored without prescale", rv, 6);

    // R2 overflow with and without reload
    wr(ARL, 32'h100);
    wr(ACNT, 32'hFFFF_FFFE);
    run_for(32'h2, 3);
    rd(ACNT); chk("R2 auto-reload", rv, 32'h101);
    rd(AST);  chk("R2 overflow flag", rv, 32'h2);
    wr(AST, 32'h2);
    rd(AST);  chk("R8 write-one clears overflow", rv, 0);
    wr(ACNT, 32'hFFFF_FFFE);
    run_for(32'h0, 3);
    rd(ACNT); chk("R2 wrap to zero", rv, 1);
    wr(AST, 32'h7);

    // R4 trigger and host write priority
    wr(ARL, 32'h55);
    wr(ACNT, 7);
    wr(ATRG, 32'hDEAD);
    rd(ACNT); chk("R4 trigger reload", rv, 32'h55);
    wr(ACNT, 0);
    wr(AC, 32'h1);
    wr(ACNT, 50);
    wr(AC, 32'h0);
    rd(ACNT); chk("R4 host write beats increment", rv, 51);

    // R5 compare
    wr(AST, 32'h7);
    wr(AMT, 5);
    wr(ACNT, 0);
    run_for(32'h40, 8);
    rd(AST); chk("R5 match flag", rv & 32'h1, 1);
    wr(AST, 32'h7);
    wr(ACNT, 0);
    run_for(32'h0, 8);
    rd(AST); chk("R5 no match without compare", rv & 32'h1, 0);

    // R6 capture edge select: all selections against both edge directions
    begin
      logic [CW-1:0] exp_cap;
      exp_cap = '0;
      for (int s = 0; s < 4; s++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [CW-1:0] v;
          bit took;
          v = 32'h1000 + 32'(s * 2 + dir);
          wr(AC, 0);
          pin_edge(dir[0]);             // dir 0 -> rise, dir 1 -> fall
          wr(AST, 32'h7);
          wr(ACNT, v);
          wr(AC, 32'(s) << 8);
          pin_edge(~dir[0]);
          took = (s == 3) || (s == 1 && dir == 0) || (s == 2 && dir == 1);
          if (took) exp_cap = v;
          rd(ACAP); chk($sformatf("R6 capture value sel=%0d dir=%0d", s, dir), rv, exp_cap);
          rd(AST);  chk($sformatf("R6 capture flag sel=%0d dir=%0d", s, dir), rv & 32'h4, took ? 32'h4 : 0);
        end
      end
    end

    // R7 first-capture hold
    wr(AC, 0);
    pin_edge(1'b0);
    wr(AST, 32'h7);
    wr(ACNT, 32'hA0);
    wr(AC, 32'h2300);
    pin_edge(1'b1);
    wr(ACNT, 32'hB0);
    pin_edge(1'b0);
    rd(ACAP); chk("R7 first capture kept", rv, 32'hA0);
    wr(AC, 32'h0300);
    pin_edge(1'b1);
    rd(ACAP); chk("R7 overwrite when hold off", rv, 32'hB0);

    // R8 clear and set in the same cycle: set wins
    wr(AST, 32'h7);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(AST); wdata = 32'h4; cap_pin = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    rd(AST); chk("R8 set beats clear", rv, 32'h4);

    // R9 interrupt and wakeup masks
    wr(AIE, 32'h4);
    @(posedge clk); #1;
    chk("R9 irq enabled flag", {31'b0, irq}, 1);
    chk("R9 wake masked", {31'b0, wake}, 0);
    wr(AWE, 32'h4);
    wr(AIE, 32'h3);
    @(posedge clk); #1;
    chk("R9 wake enabled flag", {31'b0, wake}, 1);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(AST, 32'h7);
    @(posedge clk); #1;
    chk("R9 wake drops after clear", {31'b0, wake}, 0);
    wr(AWE, 0);
    wr(AIE, 0);

    // R10 toggle mode from idle level high
    wr(AC, 32'h1082);
    wr(ARL, 32'hFFFF_FFFE);
    wr(ACNT, 32'hFFFF_FFFE);
    wr(ATRG, 0);
    @(posedge clk); #1;
    chk("R10 rearm to idle level", {31'b0, tmr_out}, 1);
    run_for(32'h1082, 2);
    chk("R10 toggle after one overflow", {31'b0, tmr_out}, 0);
    run_for(32'h1082, 2);
    chk("R10 toggle after two overflows", {31'b0, tmr_out}, 1);

    // R10 pulse mode
    wr(AC, 0);
    wr(ACNT, 32'hFFFF_FFFF);
    wr(AC, 32'h1);
    @(negedge clk);
    chk("R10 pulse before overflow", {31'b0, tmr_out}, 0);
    @(negedge clk);
    chk("R10 pulse on overflow", {31'b0, tmr_out}, 1);
    @(negedge clk);
    chk("R10 pulse ends", {31'b0, tmr_out}, 0);
    wr(AC, 0);

    // R11 pin direction
    wr(AC, 32'h4000);
    @(posedge clk); #1;
    chk("R11 pin as input", {31'b0, tmr_out_en}, 0);
    wr(AC, 0);
    @(posedge clk); #1;
    chk("R11 pin driven", {31'b0, tmr_out_en}, 1);
    rd(AC); chk("R12 control readback", rv, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule